// File: doc/BRIEF.md
# Streaming Prewitt Edge Magnitude

This block turns a raster of 8-bit grayscale pixels into an edge-strength image. Each input beat carries a vertical strip of `LANES` pixels from one column. The block keeps only the two lowest rows of the previous strip in a line buffer. Every beat therefore adds one full column of `LANES + 2` pixels to a three-column sliding register. From that register, `LANES` vertically adjacent 3x3 windows are evaluated in the same cycle, so each input pixel is fetched exactly once.

For each window the block forms a horizontal and a vertical Prewitt gradient. It sums their squares and takes an exact floor integer square root in a fully pipelined, bit-per-stage unit. One beat of `LANES` magnitudes can be produced every cycle. Flow control on both sides is valid/ready. The whole pipeline stalls as one when the consumer holds off.

An output beat refers to the position one row above and one column left of the input beat that completed it. Windows therefore never wait for rows or columns that have not arrived yet, and the stream needs no flush beats. The last row and the last column are border pixels, which are zero by definition, so they are never emitted.

Top module: `prewitt_edge`

## Requirements
- R1: An input beat at strip s, column x carries pixel (row s*LANES+k, column x) in `inPix[8k+7:8k]`. Beats arrive column by column, then strip by strip. The output beat produced by that input beat carries, in `outMag[11k+10:11k]`, the result for pixel (row s*LANES+k-1, column x-1). Output beats keep input order.
- R2: For an interior pixel, gx is the sum of the three right-column pixels minus the sum of the three left-column pixels. gy is the sum of the three lower-row pixels minus the sum of the three upper-row pixels.
- R3: Each output equals floor(sqrt(gx*gx + gy*gy)) as an 11-bit unsigned value. It never exceeds 1081 for 8-bit pixels.
- R4: A result whose position has row below 1 or column below 1 is zero. This covers row 0, column 0, and the placeholder row -1 and column -1.
- R5: Windows that span two strips combine the two buffered rows of the previous strip with the current strip, exactly as if the whole frame were stored.
- R6: With the output always ready, a beat accepted at a clock edge produces its output valid after 14 clock edges, counting the accepting edge, and one beat is accepted per cycle.
- R7: While `outValid` is high and `outReady` is low, `outValid` stays high and `outMag` stays unchanged in the next cycle.
- R8: `inReady` is high exactly when `outReady` is high or `outValid` is low.
- R9: After reset `outValid` is low, `inReady` is high, and the next input beat is taken as strip 0, column 0 of a new frame.
- R10: After the last column of the last strip, the next beat starts a new frame at strip 0, column 0. Its results obey R4 and do not depend on the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Block accepts the input beat |
| inPix | input | LANES*8 | Vertical strip of pixels, lane 0 topmost |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Consumer accepts the output beat |
| outMag | output | LANES*11 | Edge magnitudes, lane 0 topmost |

## Verification
The hardest case to reach from the ports is a stall that freezes the pipeline while the sliding column register and the line buffer sit at a strip seam. A wrong enable there corrupts only the windows that straddle two strips. The stimulus reaches this case with a horizontal step placed across the seam and with random frames. Both are driven with random gaps on input valid and random backpressure on output ready, so stalls land at every column and lane alignment. A reset issued in the middle of a frame then shows that the frame position restarts cleanly.

// File: rtl/prewitt_pkg.sv
package prewitt_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic adv;       // whole pipeline moves one step
    logic take;      // an input beat is accepted this cycle
    logic colEdge;   // accepted beat centres on column -1 or 0
    logic topStrip;  // accepted beat belongs to the first strip
  } ctlStrobe_t;
endpackage

// File: rtl/prewitt_isqrt_step.sv
module prewitt_isqrt_step #(
  parameter int RAD_W = 22,
  parameter int REM_W = 14,
  parameter int MAG_W = 11,
  parameter int BIT   = 10
) (
  input  logic             clk,
  input  logic             en,
  input  logic [RAD_W-1:0] radIn,
  input  logic [REM_W-1:0] remIn,
  input  logic [MAG_W-1:0] rootIn,
  output logic [RAD_W-1:0] radOut,
  output logic [REM_W-1:0] remOut,
  output logic [MAG_W-1:0] rootOut
);
  logic [REM_W-1:0] remSh, trial, remNext;
  logic [MAG_W-1:0] rootNext;
  logic             fits;

  always_comb begin
    remSh    = REM_W'({remIn, radIn[2*BIT+1 -: 2]});
    trial    = REM_W'({rootIn, 2'b01});
    fits     = (remSh >= trial);
    remNext  = fits ? (remSh - trial) : remSh;
    rootNext = MAG_W'({rootIn, fits});
  end

  always_ff @(posedge clk) begin
    if (en) begin
      radOut  <= radIn;
      remOut  <= remNext;
      rootOut <= rootNext;
    end
  end
endmodule

// File: rtl/prewitt_ctrl.sv
module prewitt_ctrl
  import prewitt_pkg::*;
#(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512,
  parameter int LANES = 4,
  parameter int LAT   = 14
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic                      outReady,
  output logic                      inReady,
  output logic                      outValid,
  output logic [$clog2(IMG_W)-1:0]  colIdx,
  output ctlStrobe_t                strobe
);
  localparam int COL_W   = $clog2(IMG_W);
  localparam int STRIPS  = IMG_H / LANES;
  localparam int STRIP_W = (STRIPS > 1) ? $clog2(STRIPS) : 1;

  logic [COL_W-1:0]   colCnt;
  logic [STRIP_W-1:0] stripCnt;
  logic [LAT-1:0]     vPipe;
  logic               adv, take;

  assign adv      = outReady || !vPipe[LAT-1];
  assign take     = inValid && adv;
  assign inReady  = adv;
  assign outValid = vPipe[LAT-1];
  assign colIdx   = colCnt;

  always_comb begin
    strobe.adv      = adv;
    strobe.take     = take;
    strobe.colEdge  = (colCnt < COL_W'(2));
    strobe.topStrip = (stripCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPipe    <= '0;
      colCnt   <= '0;
      stripCnt <= '0;
    end else begin
      if (adv) vPipe <= {vPipe[LAT-2:0], take};
      if (take) begin
        if (colCnt == COL_W'(IMG_W-1)) begin
          colCnt   <= '0;
          stripCnt <= (stripCnt == STRIP_W'(STRIPS-1)) ? '0 : stripCnt + 1'b1;
        end else begin
          colCnt <= colCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/prewitt_data.sv
module prewitt_data
  import prewitt_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 4,
  parameter int IMG_W = 512,
  parameter int MAG_W = 11
) (
  input  logic                     clk,
  input  ctlStrobe_t               strobe,
  input  logic [$clog2(IMG_W)-1:0] colIdx,
  input  logic [LANES*PIX_W-1:0]   inPix,
  output logic [LANES*MAG_W-1:0]   outMag
);
  localparam int GRAD_W = PIX_W + 3;
  localparam int SUM_W  = 2 * PIX_W + 5;
  localparam int RAD_W  = 2 * MAG_W;
  localparam int REM_W  = MAG_W + 3;
  localparam int COLS   = LANES + 2;

  // line buffer: two lowest rows of the previous strip, one entry per column
  logic [2*PIX_W-1:0] lbMem [IMG_W];
  logic [2*PIX_W-1:0] lbRd;
  logic [PIX_W-1:0]   colVec [COLS];
  logic [PIX_W-1:0]   win0 [COLS];
  logic [PIX_W-1:0]   win1 [COLS];
  logic [PIX_W-1:0]   win2 [COLS];
  logic [LANES-1:0]   zeroMask, maskNext;

  assign lbRd = lbMem[colIdx];

  always_comb begin
    colVec[0] = lbRd[PIX_W-1:0];
    colVec[1] = lbRd[2*PIX_W-1:PIX_W];
    for (int k = 0; k < LANES; k++) begin
      colVec[k+2] = inPix[k*PIX_W +: PIX_W];
      maskNext[k] = strobe.colEdge || (strobe.topStrip && k < 2);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.take) begin
      win0     <= win1;
      win1     <= win2;
      win2     <= colVec;
      zeroMask <= maskNext;
      lbMem[colIdx] <= {inPix[(LANES-1)*PIX_W +: PIX_W], inPix[(LANES-2)*PIX_W +: PIX_W]};
    end
  end

  function automatic logic [GRAD_W-1:0] tri3(input logic [PIX_W-1:0] a, b, c);
    return GRAD_W'(a) + GRAD_W'(b) + GRAD_W'(c);
  endfunction

  function automatic logic [SUM_W-1:0] sqOf(input logic [GRAD_W-1:0] g);
    logic [SUM_W-1:0] e;
    e = {{(SUM_W-GRAD_W){g[GRAD_W-1]}}, g};
    return e * e;
  endfunction

  // stage 1: gradients
  logic [GRAD_W-1:0] gxN [LANES];
  logic [GRAD_W-1:0] gyN [LANES];
  logic [GRAD_W-1:0] gxQ [LANES];
  logic [GRAD_W-1:0] gyQ [LANES];

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      gxN[k] = tri3(win2[k], win2[k+1], win2[k+2]) - tri3(win0[k], win0[k+1], win0[k+2]);
      gyN[k] = tri3(win0[k+2], win1[k+2], win2[k+2]) - tri3(win0[k], win1[k], win2[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.adv) begin
      for (int k = 0; k < LANES; k++) begin
        gxQ[k] <= zeroMask[k] ? '0 : gxN[k];
        gyQ[k] <= zeroMask[k] ? '0 : gyN[k];
      end
    end
  end

  // stage 2: sum of squares
  logic [SUM_W-1:0] sumQ [LANES];

  always_ff @(posedge clk) begin
    if (strobe.adv) begin
      for (int k = 0; k < LANES; k++) sumQ[k] <= sqOf(gxQ[k]) + sqOf(gyQ[k]);
    end
  end

  // root pipeline, one result bit per stage
  logic [RAD_W-1:0] radW  [MAG_W+1][LANES];
  logic [REM_W-1:0] remW  [MAG_W+1][LANES];
  logic [MAG_W-1:0] rootW [MAG_W+1][LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign radW[0][k]  = RAD_W'(sumQ[k]);
    assign remW[0][k]  = '0;
    assign rootW[0][k] = '0;
    for (genvar s = 0; s < MAG_W; s++) begin : g_stage
      prewitt_isqrt_step #(
        .RAD_W(RAD_W), .REM_W(REM_W), .MAG_W(MAG_W), .BIT(MAG_W-1-s)
      ) u_step (
        .clk    (clk),
        .en     (strobe.adv),
        .radIn  (radW[s][k]),
        .remIn  (remW[s][k]),
        .rootIn (rootW[s][k]),
        .radOut (radW[s+1][k]),
        .remOut (remW[s+1][k]),
        .rootOut(rootW[s+1][k])
      );
    end
    assign outMag[k*MAG_W +: MAG_W] = rootW[MAG_W][k];
  end
endmodule

// File: rtl/prewitt_edge.sv
module prewitt_edge
  import prewitt_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 4,
  parameter int IMG_W = 512,
  parameter int IMG_H = 512
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  inValid,
  output logic                                  inReady,
  input  logic [LANES*PIX_W-1:0]                inPix,
  output logic                                  outValid,
  input  logic                                  outReady,
  output logic [LANES*((2*PIX_W+6)/2)-1:0]      outMag
);
  localparam int SUM_W = 2 * PIX_W + 5;
  localparam int MAG_W = (SUM_W + 1) / 2;
  localparam int LAT   = MAG_W + 3;
  localparam int COL_W = $clog2(IMG_W);

  ctlStrobe_t       strobe;
  logic [COL_W-1:0] colIdx;

  prewitt_ctrl #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .LANES(LANES), .LAT(LAT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .colIdx  (colIdx),
    .strobe  (strobe)
  );

  prewitt_data #(
    .PIX_W(PIX_W), .LANES(LANES), .IMG_W(IMG_W), .MAG_W(MAG_W)
  ) u_data (
    .clk   (clk),
    .strobe(strobe),
    .colIdx(colIdx),
    .inPix (inPix),
    .outMag(outMag)
  );
endmodule

// File: rtl/prewitt_edge_chk.sv
module prewitt_edge_chk #(
  parameter int PIX_W = 8,
  parameter int LANES = 4,
  parameter int IMG_W = 512,
  parameter int MAG_W = 11,
  parameter int LAT   = 14
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   inReady,
  input logic                   outValid,
  input logic                   outReady,
  input logic [LANES*MAG_W-1:0] outMag
);
  localparam int GMAX  = 3 * ((1 << PIX_W) - 1);
  localparam int MAXSQ = 2 * GMAX * GMAX;
  localparam int COL_W = $clog2(IMG_W);
  localparam int OCC_W = $clog2(LAT + 2) + 1;

  logic [COL_W-1:0] outCol;
  logic [OCC_W-1:0] occ;
  logic             overMax;

  always_comb begin
    overMax = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (int'(outMag[k*MAG_W +: MAG_W]) * int'(outMag[k*MAG_W +: MAG_W]) > MAXSQ) overMax = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCol <= '0;
      occ    <= '0;
    end else begin
      if (outValid && outReady) outCol <= (outCol == COL_W'(IMG_W-1)) ? '0 : outCol + 1'b1;
      occ <= occ + OCC_W'(inValid && inReady) - OCC_W'(outValid && outReady);
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outMag));

  assert_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  assert_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !overMax);

  assert_border_col_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outCol < COL_W'(2) |-> outMag == '0);

  assert_occupancy_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> occ != '0 && occ <= OCC_W'(LAT));
endmodule

bind prewitt_edge prewitt_edge_chk #(
  .PIX_W(PIX_W), .LANES(LANES), .IMG_W(IMG_W), .MAG_W(MAG_W), .LAT(LAT)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .outValid(outValid),
  .outReady(outReady),
  .outMag  (outMag)
);

// File: tb/sim_prewitt_edge.sv
`timescale 1ns/1ps
module sim_prewitt_edge;
  localparam int W = 16, H = 8, L = 4, PW = 8, MW = 11, NFR = 8, LAT = 14;
  localparam int STRIPS = H / L;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN, inValid, inReady, outValid, outReady;
  logic [L*PW-1:0]   inPix;
  logic [L*MW-1:0]   outMag;

  prewitt_edge #(.PIX_W(PW), .LANES(L), .IMG_W(W), .IMG_H(H)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inPix(inPix),
    .outValid(outValid), .outReady(outReady), .outMag(outMag)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [7:0] pixMem [2][H][W];
  int inFrame, inCol, inStrip, outFrame, outCol, outStrip, acc0;
  bit loaded, justAcc, prevStall, midDone, fast;
  logic [L*MW-1:0] prevMag;

  task automatic check(input bit ok, input string tag, input string what, input int got, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  function automatic logic [7:0] pixGen(input int m, input int r, input int c);
    case (m)
      0: return 8'd77;                          // flat
      1: return (c >= 8) ? 8'd255 : 8'd0;       // vertical step
      2: return (r >= 4) ? 8'd200 : 8'd10;      // horizontal step on the strip seam
      3: return 8'((r * 37 + c * 11) & 255);    // ramp
      default: return 8'($urandom & 255);
    endcase
  endfunction

  function automatic int isqrt(input int v);
    int r = 0;
    for (int b = 11; b >= 0; b--) if ((r + (1 << b)) * (r + (1 << b)) <= v) r += (1 << b);
    return r;
  endfunction

  function automatic int expMag(input int p, input int r, input int c);
    int gx = 0, gy = 0;
    if (r < 1 || c < 1 || r > H - 2 || c > W - 2) return 0;
    for (int d = -1; d <= 1; d++) begin
      gx += int'(pixMem[p][r+d][c+1]) - int'(pixMem[p][r+d][c-1]);
      gy += int'(pixMem[p][r+1][c+d]) - int'(pixMem[p][r-1][c+d]);
    end
    return isqrt(gx * gx + gy * gy);
  endfunction

  task automatic printSummary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rstN = 0; inValid = 0; outReady = 0; inPix = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check(outValid == 1'b0, "R9", "outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R9", "inReady after reset", int'(inReady), 1);
    inFrame = 0; inCol = 0; inStrip = 0; outFrame = 0; outCol = 0; outStrip = 0;
    loaded = 0; justAcc = 0; prevStall = 0; midDone = 0; acc0 = 0;
    while (outFrame < NFR && !done) begin
      @(negedge clk);
      if (!midDone && inFrame == 5 && inStrip == 0 && inCol == 10) begin
        // reset in the middle of a frame
        rstN = 0; inValid = 0; outReady = 0;
        @(negedge clk); @(negedge clk);
        rstN = 1;
        #1;
        check(outValid == 1'b0, "R9", "outValid after mid-frame reset", int'(outValid), 0);
        check(inReady == 1'b1, "R9", "inReady after mid-frame reset", int'(inReady), 1);
        inFrame++; outFrame = inFrame;
        inCol = 0; inStrip = 0; outCol = 0; outStrip = 0;
        loaded = 0; justAcc = 0; prevStall = 0; midDone = 1;
        continue;
      end
      if (!loaded && inFrame < NFR) begin
        for (int k = 0; k < L; k++) begin
          logic [7:0] v;
          v = pixGen(inFrame, inStrip * L + k, inCol);
          pixMem[inFrame & 1][inStrip * L + k][inCol] = v;
          inPix[k*PW +: PW] = v;
        end
        loaded = 1;
      end
      fast = (inFrame == 0);
      if (!loaded) inValid = 0;
      else if (!inValid || justAcc) inValid = fast || ($urandom % 4 != 0);
      justAcc = 0;
      outReady = fast ? 1'b1 : ($urandom % 3 != 0);
      #1;
      check(inReady == (outReady || !outValid), "R8", "inReady rule", int'(inReady), int'(outReady || !outValid));
      if (prevStall) begin
        check(outValid == 1'b1, "R7", "outValid held under backpressure", int'(outValid), 1);
        check(outMag == prevMag, "R7", "outMag held under backpressure", int'(outMag[MW-1:0]), int'(prevMag[MW-1:0]));
      end
      if (outValid && outReady) begin
        if (outFrame == 0 && outStrip == 0 && outCol == 0)
          check(cyc - acc0 == LAT, "R6", "latency in edges", cyc - acc0, LAT);
        for (int k = 0; k < L; k++) begin
          int r, c, e, g;
          string tag;
          r = outStrip * L + k - 1;
          c = outCol - 1;
          e = expMag(outFrame & 1, r, c);
          g = int'(outMag[k*MW +: MW]);
          if (r < 1 || c < 1) tag = "R4";
          else if (outFrame > 0 && outStrip == 0) tag = "R10";
          else if (k < 2) tag = "R5";
          else tag = "R3";
          check(g == e, tag, $sformatf("(R1,R2) frame %0d row %0d col %0d lane %0d", outFrame, r, c, k), g, e);
        end
        outCol++;
        if (outCol == W) begin
          outCol = 0; outStrip++;
          if (outStrip == STRIPS) begin outStrip = 0; outFrame++; end
        end
      end
      if (inValid && inReady) begin
        if (inFrame == 0 && inStrip == 0 && inCol == 0) acc0 = cyc;
        justAcc = 1; loaded = 0;
        inCol++;
        if (inCol == W) begin
          inCol = 0; inStrip++;
          if (inStrip == STRIPS) begin inStrip = 0; inFrame++; end
        end
      end
      prevStall = outValid && !outReady;
      prevMag = outMag;
    end
    if (!done) begin
      done = 1;
      printSummary();
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: run did not complete, actual=%0d expected=%0d", outFrame, NFR);
      printSummary();
      $finish;
    end
  end
endmodule